// File: doc/BRIEF.md
# Paged Memory and I/O Access Controller

This block stands between a small soft processor core and on-chip RAM built from 16-bit words. The processor issues requests with a 16-bit offset that is always relative to the start of the current page. The controller joins that offset to a page register to form the physical RAM address. Because every program module addresses only its own page, it can be placed in any page without changing its code.

The top sixteen offsets of every page form an I/O window. Plain reads and writes there go to a separate I/O port that means the same registers whatever page is current. These accesses are stretched by a parameterised number of wait cycles so that slow peripherals can keep up. The controller also keeps one stack pointer per page, so each resident module has its own stack. Push and pop requests use the pointer of the current page.

Requests use a valid/ready handshake, and only one is outstanding at a time. Each accepted request produces exactly one single-cycle response pulse.

Top module: `pgmem_ctrl`

## Requirements
- R1: A read (op code 2'b00) or write (op code 2'b01) to an offset below 0xFFF0 drives the RAM with address {page, offset}. The page number occupies the upper PAGE_W bits of ram_addr_o.
- R2: A pulse on set_page_i loads page_val_i into the page register. A request accepted in the same cycle as that pulse still uses the previous page. Every later request uses the new page.
- R3: A read or write to offsets 0xFFF0 through 0xFFFF, on any page, drives the I/O port with io_addr_o equal to the offset's low 4 bits and never enables the RAM. Offset 0xFFEF still goes to RAM.
- R4: An I/O access holds io_en_o high for IO_WAIT+1 consecutive cycles, with stable address, write flag and data. The response comes IO_WAIT+2 cycles after acceptance and carries the value io_rdata_i had in the last enabled cycle.
- R5: A RAM access raises ram_en_o for exactly the one cycle after acceptance. The response follows in the next cycle, 2 cycles after acceptance. For a read, the response returns ram_rdata_i; for a write or push, it returns zero.
- R6: req_ready_o is high only when no request is outstanding. It is low from the cycle after acceptance through the response cycle, and high again in the cycle after the response.
- R7: Every page's stack pointer resets to 0xFFEF. A push (op code 2'b10) first decrements the current page's pointer, then writes req_wdata_i at {page, new pointer}.
- R8: A pop (op code 2'b11) reads {page, pointer} and then increments the current page's pointer. The pointers of all other pages are left unchanged.
- R9: Push and pop always address RAM, even when the pointer lies inside the I/O window.
- R10: During and right after reset, req_ready_o is high, rsp_valid_o, ram_en_o and io_en_o are low, and the page register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_page_i | input | 1 | Strobe that loads a new page number |
| page_val_i | input | PAGE_W | Page number loaded by set_page_i |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle; a request is taken when valid and ready are both high |
| req_op_i | input | 2 | Operation: 00 read, 01 write, 10 push, 11 pop |
| req_addr_i | input | 16 | In-page offset (ignored by push and pop) |
| req_wdata_i | input | 16 | Write or push data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read or pop data; zero for writes |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | PAGE_W+16 | Physical RAM address {page, offset} |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, valid one cycle after an enabled read |
| io_en_o | output | 1 | I/O access enable, held for the stretched access |
| io_we_o | output | 1 | I/O write flag |
| io_addr_o | output | IO_WIN_W | I/O register index |
| io_wdata_o | output | 16 | I/O write data |
| io_rdata_i | input | 16 | I/O read data |

## Verification
The bench builds the controller with PAGE_W at its default of 4 and IO_WAIT set to 4 rather than its default of 3. This way, the measured I/O response latency of 6 cycles and the 5-cycle enable burst can only come from the parameter and not from a hard-coded count. With 16 pages, the bench can run stacks on several pages side by side, switch pages between requests and in the same cycle as a request, and place the same I/O offset on different pages. Popping past the reset pointer drives a stack pointer into the I/O window, which reaches the rule that stack traffic never leaves RAM.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

    localparam int OFF_W  = 16;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_PUSH  = 2'b10,
        OP_POP   = 2'b11
    } mem_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAM,
        ST_IOWAIT,
        ST_RESP
    } ctl_state_e;

    typedef struct packed {
        logic             is_io;
        logic             we;
        logic [OFF_W-1:0] off;
    } access_t;

    function automatic logic [OFF_W-1:0] io_base(input int win_w);
        return {OFF_W{1'b1}} << win_w;
    endfunction

    function automatic logic in_io_window(input logic [OFF_W-1:0] off, input int win_w);
        logic [OFF_W-1:0] m;
        m = io_base(win_w);
        return (off & m) == m;
    endfunction

    function automatic logic is_stack_op(input mem_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/pgmem_decode.sv
module pgmem_decode
    import pgmem_pkg::*;
#(
    parameter int IO_WIN_W = 4
) (
    input  mem_op_e          op_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [OFF_W-1:0] sp_i,
    output access_t          acc_o,
    output logic             sp_upd_o,
    output logic [OFF_W-1:0] sp_next_o
);

    logic [OFF_W-1:0] sp_dec;
    logic [OFF_W-1:0] sp_inc;

    assign sp_dec = sp_i - 1'b1;
    assign sp_inc = sp_i + 1'b1;

    always_comb begin
        acc_o.is_io = 1'b0;
        acc_o.we    = (op_i == OP_WRITE) || (op_i == OP_PUSH);
        acc_o.off   = off_i;
        sp_upd_o    = is_stack_op(op_i);
        sp_next_o   = sp_i;
        unique case (op_i)
            OP_READ, OP_WRITE: begin
                acc_o.is_io = in_io_window(off_i, IO_WIN_W);
            end
            OP_PUSH: begin
                acc_o.off = sp_dec;
                sp_next_o = sp_dec;
            end
            OP_POP: begin
                acc_o.off = sp_i;
                sp_next_o = sp_inc;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pgmem_sp_bank.sv
module pgmem_sp_bank
    import pgmem_pkg::*;
#(
    parameter int               PAGE_W  = 4,
    parameter logic [OFF_W-1:0] SP_INIT = 16'hFFEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] sel_i,
    input  logic              upd_i,
    input  logic [OFF_W-1:0]  nxt_i,
    output logic [OFF_W-1:0]  sp_o
);

    localparam int NPAGES = 1 << PAGE_W;

    logic [OFF_W-1:0] sp_q [NPAGES];

    for (genvar g = 0; g < NPAGES; g++) begin : g_page_sp
        always_ff @(posedge clk) begin
            if (rst) begin
                sp_q[g] <= SP_INIT;
            end else if (upd_i && (sel_i == PAGE_W'(g))) begin
                sp_q[g] <= nxt_i;
            end
        end
    end

    assign sp_o = sp_q[sel_i];

endmodule

// File: rtl/pgmem_io_timer.sv
module pgmem_io_timer #(
    parameter int IO_WAIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic run_i,
    output logic last_o
);

    localparam int CNT_W = $clog2(IO_WAIT + 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(IO_WAIT);
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
    import pgmem_pkg::*;
#(
    parameter int PAGE_W   = 4,
    parameter int IO_WIN_W = 4,
    parameter int IO_WAIT  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_page_i,
    input  logic [PAGE_W-1:0]        page_val_i,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [1:0]               req_op_i,
    input  logic [15:0]              req_addr_i,
    input  logic [15:0]              req_wdata_i,
    output logic                     rsp_valid_o,
    output logic [15:0]              rsp_rdata_o,
    output logic                     ram_en_o,
    output logic                     ram_we_o,
    output logic [PAGE_W+15:0]       ram_addr_o,
    output logic [15:0]              ram_wdata_o,
    input  logic [15:0]              ram_rdata_i,
    output logic                     io_en_o,
    output logic                     io_we_o,
    output logic [IO_WIN_W-1:0]      io_addr_o,
    output logic [15:0]              io_wdata_o,
    input  logic [15:0]              io_rdata_i
);

    localparam logic [OFF_W-1:0] SP_INIT = io_base(IO_WIN_W) - 1'b1;

    ctl_state_e           state_q;
    logic [PAGE_W-1:0]    page_q;
    logic [PAGE_W-1:0]    page_l;
    access_t              acc_d;
    access_t              acc_l;
    logic [WORD_W-1:0]    wdata_l;
    logic [WORD_W-1:0]    io_rd_q;
    logic [OFF_W-1:0]     sp_cur;
    logic [OFF_W-1:0]     sp_nxt;
    logic                 sp_upd;
    logic                 accept;
    logic                 io_last;
    mem_op_e              op_in;

    assign op_in  = mem_op_e'(req_op_i);
    assign accept = req_valid_i && (state_q == ST_IDLE);

    pgmem_decode #(.IO_WIN_W(IO_WIN_W)) u_decode (
        .op_i      (op_in),
        .off_i     (req_addr_i),
        .sp_i      (sp_cur),
        .acc_o     (acc_d),
        .sp_upd_o  (sp_upd),
        .sp_next_o (sp_nxt)
    );

    pgmem_sp_bank #(.PAGE_W(PAGE_W), .SP_INIT(SP_INIT)) u_sp_bank (
        .clk   (clk),
        .rst   (rst),
        .sel_i (page_q),
        .upd_i (accept && sp_upd),
        .nxt_i (sp_nxt),
        .sp_o  (sp_cur)
    );

    pgmem_io_timer #(.IO_WAIT(IO_WAIT)) u_io_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (accept && acc_d.is_io),
        .run_i   (state_q == ST_IOWAIT),
        .last_o  (io_last)
    );

    // Page register: new value applies to requests accepted afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (set_page_i) begin
            page_q <= page_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            page_l  <= '0;
            acc_l   <= '0;
            wdata_l <= '0;
            io_rd_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        page_l  <= page_q;
                        acc_l   <= acc_d;
                        wdata_l <= req_wdata_i;
                        state_q <= acc_d.is_io ? ST_IOWAIT : ST_RAM;
                    end
                end
                ST_RAM: begin
                    state_q <= ST_RESP;
                end
                ST_IOWAIT: begin
                    if (io_last) begin
                        io_rd_q <= io_rdata_i;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready_o = (state_q == ST_IDLE);

    assign ram_en_o    = (state_q == ST_RAM);
    assign ram_we_o    = ram_en_o && acc_l.we;
    assign ram_addr_o  = {page_l, acc_l.off};
    assign ram_wdata_o = wdata_l;

    assign io_en_o     = (state_q == ST_IOWAIT);
    assign io_we_o     = io_en_o && acc_l.we;
    assign io_addr_o   = acc_l.off[IO_WIN_W-1:0];
    assign io_wdata_o  = wdata_l;

    assign rsp_valid_o = (state_q == ST_RESP);

    always_comb begin
        rsp_rdata_o = '0;
        if (rsp_valid_o && !acc_l.we) begin
            rsp_rdata_o = acc_l.is_io ? io_rd_q : ram_rdata_i;
        end
    end

endmodule

// File: rtl/pgmem_ctrl_chk.sv
module pgmem_ctrl_chk #(
    parameter int IO_WAIT  = 3,
    parameter int IO_WIN_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid_i,
    input logic                req_ready_o,
    input logic                rsp_valid_o,
    input logic                ram_en_o,
    input logic                io_en_o,
    input logic                io_we_o,
    input logic [IO_WIN_W-1:0] io_addr_o
);

    logic [15:0] io_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_run_q <= '0;
        end else if (io_en_o) begin
            io_run_q <= io_run_q + 1'b1;
        end else begin
            io_run_q <= '0;
        end
    end

    // R3: the I/O window never enables RAM
    a_r3_io_excl_ram: assert property (@(posedge clk) disable iff (rst)
        io_en_o |-> !ram_en_o);

    // R4: enable burst lasts IO_WAIT+1 cycles
    a_r4_io_stretch: assert property (@(posedge clk) disable iff (rst)
        (!io_en_o && $past(io_en_o)) |-> (io_run_q == 16'(IO_WAIT + 1)));

    // R4: address and write flag stay stable during the burst
    a_r4_io_stable: assert property (@(posedge clk) disable iff (rst)
        (io_en_o && $past(io_en_o)) |-> ($stable(io_addr_o) && $stable(io_we_o)));

    // R5: RAM enable is a single cycle followed by the response
    a_r5_ram_single: assert property (@(posedge clk) disable iff (rst)
        ram_en_o |=> (!ram_en_o && rsp_valid_o));

    // R6: one outstanding request
    a_r6_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R6: ready returns after the response
    a_r6_ready_after_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> req_ready_o);

endmodule

bind pgmem_ctrl pgmem_ctrl_chk #(.IO_WAIT(IO_WAIT), .IO_WIN_W(IO_WIN_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .ram_en_o    (ram_en_o),
    .io_en_o     (io_en_o),
    .io_we_o     (io_we_o),
    .io_addr_o   (io_addr_o)
);

// File: tb/pgmem_ctrl_tb_top.sv
module pgmem_ctrl_tb_top;

    localparam int PW    = 4;
    localparam int WW    = 4;
    localparam int TB_IO_WAIT = 4;

    typedef struct {
        bit          is_io;
        bit          we;
        logic [19:0] addr;
        logic [15:0] rdata;
        int          rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_page_i = 1'b0;
    logic [PW-1:0] page_val_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [1:0]  req_op_i = 2'b00;
    logic [15:0] req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        rsp_valid_o;
    logic [15:0] rsp_rdata_o;
    logic        ram_en_o, ram_we_o;
    logic [PW+15:0] ram_addr_o;
    logic [15:0] ram_wdata_o;
    logic [15:0] ram_rdata_i = '0;
    logic        io_en_o, io_we_o;
    logic [WW-1:0] io_addr_o;
    logic [15:0] io_wdata_o;
    logic [15:0] io_rdata_i;

    always #10 clk = ~clk;

    pgmem_ctrl #(.PAGE_W(PW), .IO_WIN_W(WW), .IO_WAIT(TB_IO_WAIT)) dut_i (
        .clk(clk), .rst(rst),
        .set_page_i(set_page_i), .page_val_i(page_val_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
        .ram_en_o(ram_en_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
        .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
        .io_en_o(io_en_o), .io_we_o(io_we_o), .io_addr_o(io_addr_o),
        .io_wdata_o(io_wdata_o), .io_rdata_i(io_rdata_i)
    );

    // Memory and peripheral models
    logic [15:0] ram_mem [logic [19:0]];
    logic [15:0] io_regs [16];

    always @(posedge clk) begin
        if (ram_en_o) begin
            if (ram_we_o) ram_mem[ram_addr_o] = ram_wdata_o;
            else ram_rdata_i <= ram_mem.exists(ram_addr_o) ? ram_mem[ram_addr_o] : 16'h0;
        end
        if (io_en_o && io_we_o) io_regs[io_addr_o] = io_wdata_o;
    end
    assign io_rdata_i = io_regs[io_addr_o];

    // Bench-side expectations
    logic [15:0] exp_mem [logic [19:0]];
    logic [15:0] exp_io [16];
    logic [15:0] tb_sp [16];
    logic [PW-1:0] tb_page = '0;
    exp_t        q[$];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int io_run = 0;
    bit ram_seen = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic finish_tb();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_tb();
        end
    end

    function automatic logic [15:0] mem_lookup(input logic [19:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 16'h0;
    endfunction

    // Driver: computes expected item, pushes it, then drives the request
    task automatic issue(input logic [1:0] op, input logic [15:0] off, input logic [15:0] wd,
                         input bit set_pg, input logic [PW-1:0] npg, input int rq);
        exp_t e;
        logic [PW-1:0] p;
        p = tb_page;
        e.is_io = 0; e.we = 0; e.rdata = 16'h0; e.rq = rq;
        case (op)
            2'b00, 2'b01: begin
                e.is_io = (off >= 16'hFFF0);
                e.addr  = {p, off};
                e.we    = (op == 2'b01);
                if (e.is_io) begin
                    if (e.we) exp_io[off[3:0]] = wd; else e.rdata = exp_io[off[3:0]];
                end else begin
                    if (e.we) exp_mem[e.addr] = wd; else e.rdata = mem_lookup(e.addr);
                end
            end
            2'b10: begin
                tb_sp[p] = tb_sp[p] - 16'h1;
                e.addr = {p, tb_sp[p]};
                e.we = 1;
                exp_mem[e.addr] = wd;
            end
            default: begin
                e.addr = {p, tb_sp[p]};
                e.rdata = mem_lookup(e.addr);
                tb_sp[p] = tb_sp[p] + 16'h1;
            end
        endcase
        if (set_pg) tb_page = npg;
        q.push_back(e);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1; req_op_i = op; req_addr_i = off; req_wdata_i = wd;
        set_page_i = set_pg; page_val_i = npg;
        @(negedge clk);
        req_valid_i = 0; set_page_i = 0;
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic set_page(input logic [PW-1:0] npg);
        set_page_i = 1; page_val_i = npg;
        @(negedge clk);
        set_page_i = 0;
        tb_page = npg;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (req_valid_i && req_ready_o) begin
                acc_cyc = cyc; io_run = 0; ram_seen = 0;
            end
            if (ram_en_o) begin
                ram_seen = 1;
                if (q.size() > 0) begin
                    chk(!q[0].is_io, "R3", "RAM enabled for window access", 32'(ram_en_o), 32'h0);
                    chk(ram_addr_o == q[0].addr, $sformatf("R%0d", q[0].rq), "ram address",
                        32'(ram_addr_o), 32'(q[0].addr));
                    chk(ram_we_o == q[0].we, $sformatf("R%0d", q[0].rq), "ram write flag",
                        32'(ram_we_o), 32'(q[0].we));
                end
            end
            if (io_en_o) begin
                if (io_run == 0 && q.size() > 0)
                    chk(q[0].is_io && io_addr_o == q[0].addr[3:0], "R3", "io index",
                        32'(io_addr_o), 32'(q[0].addr[3:0]));
                io_run++;
            end
            if (rsp_valid_o) begin
                if (q.size() == 0) begin
                    chk(0, "R6", "response with nothing outstanding", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(!req_ready_o, "R6", "ready during response", 32'(req_ready_o), 32'h0);
                    if (e.is_io) begin
                        chk(cyc - acc_cyc == TB_IO_WAIT + 2, "R4", "io latency",
                            32'(cyc - acc_cyc), 32'(TB_IO_WAIT + 2));
                        chk(io_run == TB_IO_WAIT + 1 && !ram_seen, "R4", "io enable burst",
                            32'(io_run), 32'(TB_IO_WAIT + 1));
                    end else begin
                        chk(cyc - acc_cyc == 2 && ram_seen && io_run == 0, "R5", "ram latency",
                            32'(cyc - acc_cyc), 32'h2);
                    end
                    chk(rsp_rdata_o == e.rdata, $sformatf("R%0d", e.rq), "response data",
                        32'(rsp_rdata_o), 32'(e.rdata));
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            io_regs[i] = 16'hA000 + 16'(i);
            exp_io[i]  = 16'hA000 + 16'(i);
            tb_sp[i]   = 16'hFFEF;
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready_o == 1, "R10", "ready in reset", 32'(req_ready_o), 32'h1);
        chk(!rsp_valid_o && !ram_en_o && !io_en_o, "R10", "strobes in reset",
            {29'h0, rsp_valid_o, ram_en_o, io_en_o}, 32'h0);
        rst = 0;
        @(negedge clk);
        chk(req_ready_o == 1 && !rsp_valid_o, "R10", "idle after reset", 32'(req_ready_o), 32'h1);

        // R1 R5: write and read back on page 0
        issue(2'b01, 16'h1234, 16'hBEEF, 0, '0, 1);
        issue(2'b00, 16'h1234, 16'h0, 0, '0, 5);
        // R1 R2: other page holds different data at same offset
        set_page(4'd3);
        issue(2'b01, 16'h1234, 16'h3333, 0, '0, 1);
        issue(2'b00, 16'h1234, 16'h0, 0, '0, 1);
        set_page(4'd0);
        issue(2'b00, 16'h1234, 16'h0, 0, '0, 2);
        // R2: page strobe with request in same cycle uses old page
        issue(2'b00, 16'h1234, 16'h0, 1, 4'd5, 2);
        issue(2'b00, 16'h1234, 16'h0, 0, '0, 2);
        // R3 R4: I/O window identical across pages
        issue(2'b01, 16'hFFF2, 16'h5A5A, 0, '0, 3);
        set_page(4'd9);
        issue(2'b00, 16'hFFF2, 16'h0, 0, '0, 3);
        issue(2'b00, 16'hFFFF, 16'h0, 0, '0, 4);
        issue(2'b00, 16'hFFF0, 16'h0, 0, '0, 3);
        // R3 boundary: offset just below the window is RAM
        issue(2'b01, 16'hFFEF, 16'h0C0C, 0, '0, 3);
        issue(2'b00, 16'hFFEF, 16'h0, 0, '0, 3);
        // R7: pushes on page 9 and page 2
        issue(2'b10, 16'h0, 16'h1111, 0, '0, 7);
        issue(2'b10, 16'h0, 16'h2222, 0, '0, 7);
        set_page(4'd2);
        issue(2'b10, 16'h0, 16'h7777, 0, '0, 7);
        set_page(4'd9);
        issue(2'b00, 16'hFFEE, 16'h0, 0, '0, 7);
        // R8: pops in reverse order, page 2 untouched
        issue(2'b11, 16'h0, 16'h0, 0, '0, 8);
        issue(2'b11, 16'h0, 16'h0, 0, '0, 8);
        // R9: pops walk the pointer into the window, still RAM
        issue(2'b11, 16'h0, 16'h0, 0, '0, 9);
        issue(2'b11, 16'h0, 16'h0, 0, '0, 9);
        set_page(4'd2);
        issue(2'b11, 16'h0, 16'h0, 0, '0, 8);
        repeat (3) @(negedge clk);
        chk(q.size() == 0 && req_ready_o, "R6", "all responses returned", 32'(q.size()), 32'h0);
        finish_tb();
    end

endmodule